// File: doc/BRIEF.md
# Integer and Byte to Single-Precision Converter

This block is a purely combinational conversion unit that turns a 32-bit source word into an IEEE-754 single-precision value. An opcode selects how the source is read. It can be a full signed word, a full unsigned word, one of the four unsigned byte lanes, or a signed low nibble that is scaled to a small fraction. The result is valid in the same cycle as the inputs, so a surrounding pipeline can place the unit between any two of its own register stages.

Wide integers that need more significant bits than the 24-bit significand holds are rounded to nearest, with ties going to the even significand. Byte and nibble sources always fit, so their results are exact. Opcodes outside the supported set give an all-zero result.

Top module: `fpcvt_int2f32`

## Requirements
- R1: Opcode 5 reads `src_i` as a two's-complement 32-bit integer and gives its exact single-precision value when it has at most 24 significant bits. The sign bit `res_o[31]` equals `src_i[31]`.
- R2: Opcode 6 reads `src_i` as an unsigned 32-bit integer. The result always has sign bit 0 and is exact when the value has at most 24 significant bits.
- R3: For opcodes 5 and 6, a magnitude with more than 24 significant bits is rounded to nearest, with ties to even. For example, unsigned 0x01000001 gives 0x4B800000, 0x01000003 gives 0x4B800002 and 0x02000003 gives 0x4C000001.
- R4: A zero source under opcode 5 or 6 gives +0.0 (0x00000000).
- R5: Signed 0x80000000 gives exactly 0xCF000000. Signed 0x7FFFFFFF rounds to 0x4F000000.
- R6: Unsigned 0xFFFFFFFF rounds up across the exponent to 0x4F800000.
- R7: Opcodes 17, 18, 19 and 20 convert the unsigned byte at bits [7:0], [15:8], [23:16] and [31:24] respectively. The result is exact with sign bit 0, and the other three bytes have no effect.
- R8: Opcode 14 takes nibble `src_i[3:0]`, XORs it with 8, divides by 16 and subtracts 0.5. This gives the nibble's signed value divided by 16, in the range -0.5 to 0.4375. Nibble 0 gives 0x00000000, 7 gives 0x3EE00000, 8 gives 0xBF000000 and 15 gives 0xBD800000. Bits [31:4] have no effect, and the result magnitude never exceeds 0.5.
- R9: Any opcode other than 5, 6, 14 and 17 to 20 gives 0x00000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 8 | Conversion selector |
| src_i | input | 32 | Source word |
| res_o | output | 32 | Single-precision result |

## Verification
The signed and unsigned paths are driven with small exact values, negative values and the all-ones word. The all-ones word gives -1.0 under opcode 5 and rounds up to 2^32 under opcode 6, which separates the two opcodes. Three 25- and 26-bit values separate a round-down tie, a round-up tie and a sticky-bit round-up, so truncation and round-half-up both show as errors. Byte-lane patterns put a distinct value in each lane and a lone one in a single lane with all-ones elsewhere, which exposes a wrong or overlapping lane select. A sweep of all sixteen nibbles with random upper bits separates the sign handling of the offset mapping from leakage of the ignored bits.

// File: rtl/fpcvt_pkg.sv
package fpcvt_pkg;

    localparam int SRC_W   = 32;
    localparam int OP_W    = 8;
    localparam int EXP_W   = 8;
    localparam int MAN_W   = 23;
    localparam int FP_W    = 1 + EXP_W + MAN_W;
    localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
    localparam int LANE_W  = 8;
    localparam int LANES   = SRC_W / LANE_W;
    localparam int NIB_W   = 4;
    localparam int CNT_W   = $clog2(SRC_W);
    localparam int BEXP_W  = EXP_W + 1;
    localparam int GRD_POS = SRC_W - 2 - MAN_W;

    typedef enum logic [OP_W-1:0] {
        OP_SINT  = 8'd5,
        OP_UINT  = 8'd6,
        OP_NIBF  = 8'd14,
        OP_LANE0 = 8'd17,
        OP_LANE1 = 8'd18,
        OP_LANE2 = 8'd19,
        OP_LANE3 = 8'd20
    } cvt_op_e;

    // Selected operand: sign, magnitude and whether a 1/16 scale applies
    typedef struct packed {
        logic             neg;
        logic             valid;
        logic             frac;
        logic [SRC_W-1:0] mag;
    } operand_t;

    // Normalised operand: leading one at the top bit
    typedef struct packed {
        logic              neg;
        logic              zero;
        logic [BEXP_W-1:0] bexp;
        logic [SRC_W-1:0]  bits;
    } normed_t;

    function automatic logic [CNT_W-1:0] lead_zeros(input logic [SRC_W-1:0] v);
        logic [CNT_W-1:0] n;
        n = '0;
        for (int i = 0; i < SRC_W; i++) begin
            if (v[i]) n = CNT_W'(SRC_W - 1 - i);
        end
        return n;
    endfunction

endpackage

// File: rtl/fpcvt_operand_sel.sv
module fpcvt_operand_sel
    import fpcvt_pkg::*;
(
    input  logic [OP_W-1:0]  op_i,
    input  logic [SRC_W-1:0] src_i,
    output operand_t         opnd_o
);

    logic [LANE_W-1:0] lane [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane[g] = src_i[g*LANE_W +: LANE_W];
    end

    logic [SRC_W-1:0] abs_src;
    logic [NIB_W-1:0] nib;
    logic [NIB_W-1:0] nib_abs;
    logic [1:0]       lane_idx;

    always_comb begin
        abs_src  = src_i[SRC_W-1] ? (~src_i + 1'b1) : src_i;
        nib      = src_i[NIB_W-1:0];
        nib_abs  = nib[NIB_W-1] ? (~nib + 1'b1) : nib;
        lane_idx = 2'(op_i - OP_LANE0);
    end

    always_comb begin
        opnd_o = '0;
        unique case (op_i)
            OP_SINT: begin
                opnd_o.valid = 1'b1;
                opnd_o.neg   = src_i[SRC_W-1];
                opnd_o.mag   = abs_src;
            end
            OP_UINT: begin
                opnd_o.valid = 1'b1;
                opnd_o.mag   = src_i;
            end
            OP_NIBF: begin
                opnd_o.valid = 1'b1;
                opnd_o.frac  = 1'b1;
                opnd_o.neg   = nib[NIB_W-1];
                opnd_o.mag   = SRC_W'(nib_abs);
            end
            OP_LANE0, OP_LANE1, OP_LANE2, OP_LANE3: begin
                opnd_o.valid = 1'b1;
                opnd_o.mag   = SRC_W'(lane[lane_idx]);
            end
            default: opnd_o = '0;
        endcase
    end

endmodule

// File: rtl/fpcvt_normalize.sv
module fpcvt_normalize
    import fpcvt_pkg::*;
(
    input  operand_t opnd_i,
    output normed_t  norm_o
);

    logic [CNT_W-1:0]  lz;
    logic [BEXP_W-1:0] top_exp;

    always_comb begin
        lz      = lead_zeros(opnd_i.mag);
        top_exp = BEXP_W'(BIAS + SRC_W - 1) - BEXP_W'(lz);
        norm_o.neg  = opnd_i.neg;
        norm_o.zero = !opnd_i.valid || (opnd_i.mag == '0);
        norm_o.bexp = opnd_i.frac ? (top_exp - BEXP_W'(NIB_W)) : top_exp;
        norm_o.bits = opnd_i.mag << lz;
    end

endmodule

// File: rtl/fpcvt_round_pack.sv
module fpcvt_round_pack
    import fpcvt_pkg::*;
(
    input  normed_t         norm_i,
    output logic [FP_W-1:0] res_o
);

    logic [MAN_W-1:0]       man;
    logic                   guard;
    logic                   sticky;
    logic                   rnd_up;
    logic [EXP_W+MAN_W-1:0] body;

    always_comb begin
        man    = norm_i.bits[SRC_W-2 -: MAN_W];
        guard  = norm_i.bits[GRD_POS];
        sticky = |norm_i.bits[GRD_POS-1:0];
        rnd_up = guard && (sticky || man[0]);
        // a carry out of the significand moves into the exponent field
        body   = {norm_i.bexp[EXP_W-1:0], man} + (EXP_W+MAN_W)'(rnd_up);
        res_o  = norm_i.zero ? '0 : {norm_i.neg, body};
    end

endmodule

// File: rtl/fpcvt_int2f32.sv
module fpcvt_int2f32
    import fpcvt_pkg::*;
(
    input  logic [OP_W-1:0]  op_i,
    input  logic [SRC_W-1:0] src_i,
    output logic [FP_W-1:0]  res_o
);

    operand_t opnd;
    normed_t  norm;

    fpcvt_operand_sel u_sel (
        .op_i   (op_i),
        .src_i  (src_i),
        .opnd_o (opnd)
    );

    fpcvt_normalize u_norm (
        .opnd_i (opnd),
        .norm_o (norm)
    );

    fpcvt_round_pack u_pack (
        .norm_i (norm),
        .res_o  (res_o)
    );

endmodule

// File: rtl/fpcvt_int2f32_chk.sv
module fpcvt_int2f32_chk
    import fpcvt_pkg::*;
(
    input logic [OP_W-1:0]  op_i,
    input logic [SRC_W-1:0] src_i,
    input logic [FP_W-1:0]  res_o
);

    logic is_lane;
    assign is_lane = (op_i >= OP_LANE0) && (op_i <= OP_LANE3);

    always_comb begin
        if (op_i == OP_SINT)
            p_sint_sign_r1: assert (res_o[FP_W-1] == src_i[SRC_W-1])
                else $error("sign of signed conversion wrong");
        if (op_i == OP_UINT)
            p_uint_pos_r2: assert (!res_o[FP_W-1])
                else $error("unsigned conversion negative");
        if ((op_i == OP_SINT || op_i == OP_UINT) && src_i == '0)
            p_zero_pos_r4: assert (res_o == '0)
                else $error("zero source not +0.0");
        if (is_lane)
            p_lane_pos_r7: assert (!res_o[FP_W-1])
                else $error("byte conversion negative");
        if (op_i == OP_NIBF)
            p_nib_range_r8: assert (res_o[FP_W-2 -: EXP_W] <= EXP_W'(BIAS - 1))
                else $error("offset result beyond 0.5");
        if (op_i != OP_SINT && op_i != OP_UINT && op_i != OP_NIBF && !is_lane)
            p_other_zero_r9: assert (res_o == '0)
                else $error("unsupported opcode nonzero");
    end

endmodule

bind fpcvt_int2f32 fpcvt_int2f32_chk u_chk (
    .op_i  (op_i),
    .src_i (src_i),
    .res_o (res_o)
);

// File: tb/sim_fpcvt_int2f32.sv
module sim_fpcvt_int2f32;

    logic       clk = 1'b0;
    logic [7:0] op;
    logic [31:0] src;
    logic [31:0] res;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    fpcvt_int2f32 u0 (
        .op_i  (op),
        .src_i (src),
        .res_o (res)
    );

    typedef struct packed {
        logic [7:0]  op;
        logic [31:0] src;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t VEC [NV] = '{
        '{8'd5,  32'h0000_0001, 32'h3F80_0000, 8'd1},  // R1 one
        '{8'd5,  32'hFFFF_FFFB, 32'hC0A0_0000, 8'd1},  // R1 minus five
        '{8'd5,  32'h00FF_FFFF, 32'h4B7F_FFFF, 8'd1},  // R1 widest exact
        '{8'd5,  32'hFFFF_FFFF, 32'hBF80_0000, 8'd1},  // R1 minus one
        '{8'd6,  32'h0000_03E8, 32'h447A_0000, 8'd2},  // R2 1000
        '{8'd6,  32'h8000_0000, 32'h4F00_0000, 8'd2},  // R2 top bit unsigned
        '{8'd6,  32'h0100_0001, 32'h4B80_0000, 8'd3},  // R3 tie down to even
        '{8'd6,  32'h0100_0003, 32'h4B80_0002, 8'd3},  // R3 tie up to even
        '{8'd6,  32'h0100_0002, 32'h4B80_0001, 8'd3},  // R3 exact 25 bits
        '{8'd6,  32'h0200_0003, 32'h4C00_0001, 8'd3},  // R3 sticky up
        '{8'd5,  32'hFEFF_FFFF, 32'hCB80_0000, 8'd3},  // R3 negative tie
        '{8'd5,  32'h0000_0000, 32'h0000_0000, 8'd4},  // R4 signed zero
        '{8'd6,  32'h0000_0000, 32'h0000_0000, 8'd4},  // R4 unsigned zero
        '{8'd5,  32'h8000_0000, 32'hCF00_0000, 8'd5},  // R5 most negative
        '{8'd5,  32'h7FFF_FFFF, 32'h4F00_0000, 8'd5},  // R5 most positive
        '{8'd6,  32'hFFFF_FFFF, 32'h4F80_0000, 8'd6},  // R6 all ones
        '{8'd17, 32'h1234_5678, 32'h42F0_0000, 8'd7},  // R7 lane 0
        '{8'd18, 32'h1234_5678, 32'h42AC_0000, 8'd7},  // R7 lane 1
        '{8'd19, 32'h1234_5678, 32'h4250_0000, 8'd7},  // R7 lane 2
        '{8'd20, 32'h1234_5678, 32'h4190_0000, 8'd7},  // R7 lane 3
        '{8'd20, 32'hFF00_0000, 32'h437F_0000, 8'd7},  // R7 byte 255
        '{8'd17, 32'hFFFF_FF00, 32'h0000_0000, 8'd7},  // R7 lane zero
        '{8'd14, 32'hFFFF_FFF0, 32'h0000_0000, 8'd8},  // R8 nibble 0
        '{8'd14, 32'h0000_0007, 32'h3EE0_0000, 8'd8},  // R8 nibble 7
        '{8'd14, 32'h0000_0008, 32'hBF00_0000, 8'd8},  // R8 nibble 8
        '{8'd14, 32'hABCD_EF1F, 32'hBD80_0000, 8'd8},  // R8 nibble 15
        '{8'd14, 32'h0000_0004, 32'h3E80_0000, 8'd8},  // R8 nibble 4
        '{8'd0,  32'h1234_5678, 32'h0000_0000, 8'd9},  // R9 opcode 0
        '{8'd7,  32'hFFFF_FFFF, 32'h0000_0000, 8'd9},  // R9 opcode 7
        '{8'd21, 32'h0000_00FF, 32'h0000_0000, 8'd9}   // R9 opcode 21
    };

    task automatic apply(input logic [7:0] o, input logic [31:0] s);
        @(negedge clk);
        op  = o;
        src = s;
        @(posedge clk);
        #5;
    endtask

    task automatic check(input string tag, input logic [31:0] expv);
        n_chk++;
        if (res !== expv) begin
            n_fail++;
            $display("FAIL %s op=%0d src=%h actual=%h expected=%h", tag, op, src, res, expv);
        end
    endtask

    initial begin
        op  = 8'd0;
        src = 32'h0;
        // idle state: default opcode gives zero (R9)
        apply(8'd0, 32'hDEAD_BEEF);
        check("R9", 32'h0);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i].op, VEC[i].src);
            check($sformatf("R%0d", VEC[i].req), VEC[i].exp);
        end

        // R7: a lone one in one lane, all-ones in the others
        for (int l = 0; l < 4; l++) begin
            apply(8'(17 + l), 32'h1 << (8 * l));
            check("R7", 32'h3F80_0000);
            apply(8'(17 + l), ~(32'hFF << (8 * l)));
            check("R7", 32'h0);
        end

        // R8: upper bits never change the offset result
        for (int n = 0; n < 16; n++) begin
            logic [31:0] ref_res;
            apply(8'd14, 32'(n));
            ref_res = res;
            apply(8'd14, {$urandom()} & 32'hFFFF_FFF0 | 32'(n));
            check("R8", ref_res);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule